// File: doc/BRIEF.md
# EEPROM Page-Load and Program-Cycle Controller

This block sits between a bus front end that has already decoded write strobes and a byte-wide nonvolatile array model with a synchronous write port. Each accepted write pulse deposits a byte into a page buffer that holds 64 slots, and each slot carries a flag that marks it as loaded. The first byte fixes the page (upper address bits). Later bytes for that page may arrive in any order and may overwrite a slot. When no byte has been accepted for a programmable number of clocks, the load window closes and a timed programming cycle begins. That cycle copies only the flagged slots into the array, one slot per clock, in ascending offset order. It then waits out the rest of the programming time.

While the programming cycle runs, the block reports busy and ignores new write pulses. Every read during that time returns a status word instead of array data. Bit 7 is the inverse of bit 7 of the last byte accepted. Bit 6 flips on each successive status read. Once programming ends, reads pass array data through again. A byte whose page bits do not match the open page is discarded and sets a sticky error flag.

Top module: `eepp_page_prog`

## Requirements
- R1: In the idle state an accepted write pulse opens a load window for the page given by address bits [ADDR_W-1:6]. Address bits [5:0] pick one of 64 slots. Every slot written during the window is later programmed at address {page, slot}.
- R2: Programming starts on the LOAD_TIMEOUT-th rising edge after the last accepted byte. A byte that arrives on or before that edge is accepted and restarts the count. A byte sampled after that edge is not part of the load.
- R3: A write pulse during the load window whose page bits differ from the open page is discarded and does not restart the timeout. It sets page_err, which stays high until reset.
- R4: Slots may be loaded in any order. Writing a slot again in the same window replaces its data, and only the latest value is programmed.
- R5: busy is high for exactly PROG_CYCLES clocks per programming cycle. In the first 64 of those clocks, mem_we is high in the clock whose index equals a flagged slot's offset, with mem_waddr = {page, offset} and that slot's data. Unflagged addresses are never written.
- R6: Write pulses sampled while busy is high have no effect on the array, the buffer or page_err.
- R7: A read issued while busy returns rd_data[7] = inverse of bit 7 of the last accepted byte, and rd_data[5:0] = bits [5:0] of that byte.
- R8: During one programming cycle, the first read returns rd_data[6] = 1, and each later read returns the inverse of the previous read's bit 6.
- R9: A read issued while not busy returns mem_rdata at mem_raddr = rd_addr. rd_valid is high in the single clock after each sampled rd_strobe, and rd_data is valid in that clock.
- R10: While reset is asserted, busy, mem_we, page_err and rd_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_pulse | input | 1 | One-clock pulse: a write was accepted by the front end |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte to load |
| rd_strobe | input | 1 | One-clock read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| mem_raddr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data for mem_raddr, same clock |
| busy | output | 1 | Programming cycle in progress |
| page_err | output | 1 | Sticky flag: a byte for another page was discarded |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 8 | Read result: array data or status word |

## Verification
page_err is due one edge after a foreign-page pulse. busy rises on the LOAD_TIMEOUT-th edge after the last accepted byte and falls PROG_CYCLES edges later. mem_we is a combinational result of the programming count, so it appears within the same clock as the count that selects each slot. rd_valid and rd_data follow a strobe by one edge. The bench drives inputs on falling edges and steps a behavioural reference model on rising edges. On every falling edge it compares busy, page_err, the write port and the read result with that model. Directed checks probe the exact edge where busy rises, a byte that arrives on the final edge of the window, a late byte, and three consecutive status reads.

// File: rtl/eepp_pkg.sv
package eepp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_t;

  // Status word seen by a reader while programming is under way.
  function automatic logic [BYTE_W-1:0] poll_word(input logic [BYTE_W-1:0] last_byte,
                                                  input logic              tog_bit);
    return {~last_byte[7], tog_bit, last_byte[5:0]};
  endfunction

  // Width needed to count 0..limit inclusive.
  function automatic int count_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/eepp_gap_timer.sv
module eepp_gap_timer
  import eepp_pkg::*;
#(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic fire
);

  localparam int CW = count_width(LIMIT);

  logic [CW-1:0] gap_cnt;

  assign fire = run && !restart && (gap_cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (restart || !run) begin
      gap_cnt <= '0;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/eepp_page_buffer.sv
module eepp_page_buffer
  import eepp_pkg::*;
#(
  parameter int OFF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [BYTE_W-1:0] st_data,
  input  logic              clr_flags,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [BYTE_W-1:0] slot_data,
  output logic              slot_flag
);

  localparam int SLOTS = 1 << OFF_W;

  logic [SLOTS*BYTE_W-1:0] dat_flat;
  logic [SLOTS-1:0]        flg_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [BYTE_W-1:0] d_q;
    logic              f_q;
    logic              hit;

    assign hit = st_en && (st_off == OFF_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        f_q <= 1'b0;
      end else begin
        if (clr_flags) f_q <= 1'b0;
        if (hit) begin
          d_q <= st_data;
          f_q <= 1'b1;
        end
      end
    end

    assign dat_flat[g*BYTE_W +: BYTE_W] = d_q;
    assign flg_vec[g]                   = f_q;
  end

  assign slot_data = dat_flat[rd_off*BYTE_W +: BYTE_W];
  assign slot_flag = flg_vec[rd_off];

endmodule

// File: rtl/eepp_sequencer.sv
module eepp_sequencer
  import eepp_pkg::*;
#(
  parameter int OFF_W       = 6,
  parameter int PAGE_W      = 9,
  parameter int PROG_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              gap_fire,
  output logic              loading,
  output logic              busy,
  output logic              accept_ev,
  output logic              drop_ev,
  output logic              prog_done,
  output logic              prog_slot,
  output logic [OFF_W-1:0]  prog_off,
  output logic [PAGE_W-1:0] cur_page,
  output logic              page_err
);

  localparam int SLOTS = 1 << OFF_W;
  localparam int SPAN  = (PROG_CYCLES > SLOTS) ? PROG_CYCLES : SLOTS;
  localparam int PCW   = count_width(SPAN);

  seq_state_t      st;
  logic [PCW-1:0]  pcnt;
  logic            page_match;

  assign page_match = (wr_page == cur_page);
  assign loading    = (st == ST_LOAD);
  assign busy       = (st == ST_PROG);
  assign accept_ev  = wr_pulse && ((st == ST_IDLE) || (loading && page_match));
  assign drop_ev    = wr_pulse && loading && !page_match;
  assign prog_done  = busy && (pcnt == PCW'(PROG_CYCLES - 1));
  assign prog_slot  = busy && (pcnt < PCW'(SLOTS));
  assign prog_off   = pcnt[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pcnt     <= '0;
      cur_page <= '0;
      page_err <= 1'b0;
    end else begin
      if (drop_ev) page_err <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (accept_ev) begin
            cur_page <= wr_page;
            st       <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (gap_fire) begin
            pcnt <= '0;
            st   <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (prog_done) begin
            pcnt <= '0;
            st   <= ST_IDLE;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eepp_poll_status.sv
module eepp_poll_status
  import eepp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] cap_data,
  input  logic              rd_strobe,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);

  logic [BYTE_W-1:0] last_q;
  logic              tog_q;
  logic              tog_next;

  assign tog_next = ~tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      tog_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (cap_en) last_q <= cap_data;
      if (!busy) begin
        tog_q <= 1'b0;
      end else if (rd_strobe) begin
        tog_q <= tog_next;
      end
      rd_valid <= rd_strobe;
      if (rd_strobe) begin
        rd_data <= busy ? poll_word(last_q, tog_next) : mem_rdata;
      end
    end
  end

endmodule

// File: rtl/eepp_page_prog.sv
module eepp_page_prog
  import eepp_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int OFF_W        = 6,
  parameter int LOAD_TIMEOUT = 30000,
  parameter int PROG_CYCLES  = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              page_err,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] wr_page;
  logic [OFF_W-1:0]  wr_off;
  logic [PAGE_W-1:0] cur_page;
  logic [OFF_W-1:0]  prog_off;
  logic [7:0]        slot_data;
  logic              slot_flag;
  logic              loading;
  logic              accept_ev;
  logic              drop_ev;
  logic              prog_done;
  logic              prog_slot;
  logic              timeout_fire;

  assign wr_page = wr_addr[ADDR_W-1:OFF_W];
  assign wr_off  = wr_addr[OFF_W-1:0];

  eepp_gap_timer #(.LIMIT(LOAD_TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (loading),
    .restart (accept_ev),
    .fire    (timeout_fire)
  );

  eepp_sequencer #(
    .OFF_W       (OFF_W),
    .PAGE_W      (PAGE_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pulse  (wr_pulse),
    .wr_page   (wr_page),
    .gap_fire  (timeout_fire),
    .loading   (loading),
    .busy      (busy),
    .accept_ev (accept_ev),
    .drop_ev   (drop_ev),
    .prog_done (prog_done),
    .prog_slot (prog_slot),
    .prog_off  (prog_off),
    .cur_page  (cur_page),
    .page_err  (page_err)
  );

  eepp_page_buffer #(.OFF_W(OFF_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_en     (accept_ev),
    .st_off    (wr_off),
    .st_data   (wr_data),
    .clr_flags (prog_done),
    .rd_off    (prog_off),
    .slot_data (slot_data),
    .slot_flag (slot_flag)
  );

  eepp_poll_status u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cap_en    (accept_ev),
    .cap_data  (wr_data),
    .rd_strobe (rd_strobe),
    .mem_rdata (mem_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign mem_we    = prog_slot && slot_flag;
  assign mem_waddr = {cur_page, prog_off};
  assign mem_wdata = slot_data;
  assign mem_raddr = rd_addr;

endmodule

// File: rtl/eepp_checker.sv
module eepp_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_pulse,
  input logic rd_strobe,
  input logic mem_we,
  input logic busy,
  input logic page_err,
  input logic rd_valid,
  input logic timeout_fire,
  input logic prog_done,
  input logic drop_ev
);

  assert_we_in_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !busy);

  assert_fire_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fire |=> busy);

  assert_busy_from_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(timeout_fire));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> page_err);

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_pulse) |=> $stable(page_err));

  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_valid);

  assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> !rd_valid);

endmodule

bind eepp_page_prog eepp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_pulse     (wr_pulse),
  .rd_strobe    (rd_strobe),
  .mem_we       (mem_we),
  .busy         (busy),
  .page_err     (page_err),
  .rd_valid     (rd_valid),
  .timeout_fire (timeout_fire),
  .prog_done    (prog_done),
  .drop_ev      (drop_ev)
);

// File: tb/eepp_page_prog_test.sv
`timescale 1ns/1ps
module eepp_page_prog_test;

  localparam int LT = 8;
  localparam int TW = 80;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_pulse = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_strobe = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [AW-1:0] mem_raddr;
  logic [7:0]    mem_rdata;
  logic          busy;
  logic          page_err;
  logic          rd_valid;
  logic [7:0]    rd_data;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  eepp_page_prog #(.ADDR_W(AW), .OFF_W(6), .LOAD_TIMEOUT(LT), .PROG_CYCLES(TW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .busy(busy),
    .page_err(page_err), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // array model the design writes into
  logic [7:0] dut_mem [1<<AW];
  logic [7:0] ref_mem [1<<AW];
  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      dut_mem[i] = 8'hFF;
      ref_mem[i] = 8'hFF;
    end
  end
  always @(posedge clk) if (mem_we) dut_mem[mem_waddr] <= mem_wdata;
  assign mem_rdata = dut_mem[mem_raddr];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int         m_state, m_timer, m_cnt, m_page;
  logic [7:0] m_buf [64];
  bit         m_val [64];
  bit         m_err, m_tog, m_rdv, m_rdbusy;
  logic [7:0] m_last, m_rdd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_timer = 0; m_cnt = 0; m_page = 0; m_err = 0; m_tog = 0;
      m_rdv = 0; m_rdbusy = 0; m_last = 0; m_rdd = 0;
      for (int i = 0; i < 64; i++) m_val[i] = 0;
    end else begin
      if (rd_strobe) begin
        m_rdv = 1;
        m_rdbusy = (m_state == 2);
        if (m_state == 2) begin
          m_tog = !m_tog;
          m_rdd = {~m_last[7], m_tog, m_last[5:0]};
        end else begin
          m_rdd = ref_mem[rd_addr];
        end
      end else begin
        m_rdv = 0;
      end
      if (m_state != 2) m_tog = 0;
      case (m_state)
        0: if (wr_pulse) begin
          m_page = int'(wr_addr) / 64;
          m_buf[int'(wr_addr) % 64] = wr_data;
          m_val[int'(wr_addr) % 64] = 1;
          m_last = wr_data; m_timer = 0; m_state = 1;
        end
        1: begin
          if (wr_pulse && (int'(wr_addr) / 64) == m_page) begin
            m_buf[int'(wr_addr) % 64] = wr_data;
            m_val[int'(wr_addr) % 64] = 1;
            m_last = wr_data; m_timer = 0;
          end else begin
            if (wr_pulse) m_err = 1;
            if (m_timer == LT - 1) begin m_state = 2; m_cnt = 0; end
            else m_timer++;
          end
        end
        default: begin
          if (m_cnt < 64 && m_val[m_cnt]) ref_mem[m_page*64 + m_cnt] = m_buf[m_cnt];
          if (m_cnt == TW - 1) begin
            m_state = 0;
            for (int i = 0; i < 64; i++) m_val[i] = 0;
          end else m_cnt++;
        end
      endcase
    end
  end

  // per-clock comparison away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_we;
      exp_we = (m_state == 2) && (m_cnt < 64) && m_val[m_cnt % 64];
      chk("R5 busy", busy, m_state == 2);
      chk("R3 page_err", page_err, m_err);
      chk("R5 mem_we", mem_we, exp_we);
      if (exp_we) begin
        chk("R5 mem_waddr", mem_waddr, m_page*64 + m_cnt);
        chk("R5 mem_wdata", mem_wdata, m_buf[m_cnt]);
      end
      chk("R9 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk(m_rdbusy ? "R7 R8 status word" : "R9 array read", rd_data, m_rdd);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_pulse = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_pulse = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_raw(input logic [AW-1:0] a);
    rd_strobe = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    rd_raw(a);
    chk(tag, rd_data, e);
  endtask

  task automatic wait_prog;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    chk("R10 busy in reset", busy, 0);
    chk("R10 mem_we in reset", mem_we, 0);
    chk("R10 page_err in reset", page_err, 0);
    chk("R10 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    idle(2);

    // out-of-order load with a rewrite, page 5
    wr(15'h0143, 8'h11); idle(1);
    wr(15'h017C, 8'hA5); idle(2);
    wr(15'h0143, 8'h3C);
    wr(15'h0140, 8'hC7);
    idle(LT - 1);
    chk("R2 busy before timeout edge", busy, 0);
    idle(1);
    chk("R2 busy after timeout edge", busy, 1);
    rd_raw(15'h0140);
    chk("R7 status bit7", rd_data[7], 0);
    chk("R7 status low bits", rd_data[5:0], 6'h07);
    chk("R8 first toggle", rd_data[6], 1);
    rd_raw(15'h0140);
    chk("R8 second toggle", rd_data[6], 0);
    rd_raw(15'h017C);
    chk("R8 third toggle", rd_data[6], 1);
    wr(15'h014A, 8'h55);
    while (busy) @(negedge clk);
    rd_chk(15'h0143, 8'h3C, "R4 rewritten slot");
    rd_chk(15'h017C, 8'hA5, "R1 slot 60");
    rd_chk(15'h0140, 8'hC7, "R1 slot 0");
    rd_chk(15'h014A, 8'hFF, "R6 write while busy");
    rd_chk(15'h0141, 8'hFF, "R5 unflagged slot");

    // foreign-page byte
    wr(15'h4002, 8'h21);
    wr(15'h4042, 8'h99);
    chk("R3 page_err set", page_err, 1);
    wr(15'h4005, 8'h22);
    wait_prog;
    chk("R3 page_err sticky", page_err, 1);
    rd_chk(15'h4042, 8'hFF, "R3 dropped byte");
    rd_chk(15'h4002, 8'h21, "R1 page 0x100 slot 2");
    rd_chk(15'h4005, 8'h22, "R1 page 0x100 slot 5");

    // full page, descending offsets
    for (int o = 63; o >= 0; o--) wr(15'h7FC0 + AW'(o), 8'(o*3 + 1));
    while (!busy) @(negedge clk);
    rd_raw(15'h7FC0);
    chk("R7 bit7 of last byte 0x01", rd_data[7], 1);
    while (busy) @(negedge clk);
    rd_chk(15'h7FC0, 8'h01, "R1 full page slot 0");
    rd_chk(15'h7FDF, 8'(31*3 + 1), "R1 full page slot 31");
    rd_chk(15'h7FFF, 8'(63*3 + 1), "R1 full page slot 63");

    // byte on the final edge of the window is accepted
    wr(15'h0200, 8'h5A);
    idle(LT - 1);
    wr(15'h0201, 8'h6B);
    chk("R2 window extended", busy, 0);
    wait_prog;
    rd_chk(15'h0200, 8'h5A, "R2 boundary first byte");
    rd_chk(15'h0201, 8'h6B, "R2 boundary second byte");

    // byte one edge too late is not part of the load
    wr(15'h0240, 8'h01);
    idle(LT);
    wr(15'h0241, 8'h02);
    while (busy) @(negedge clk);
    rd_chk(15'h0240, 8'h01, "R2 on-time byte");
    rd_chk(15'h0241, 8'hFF, "R2 late byte ignored");

    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule